// File: doc/BRIEF.md
# Sequential DES Round Key Generator

This block turns a 64-bit DES key into the sixteen 48-bit round subkeys and hands them out one at a time, one per accepted step pulse. A cipher datapath that runs one round per cycle can then take its subkey straight from this block. This avoids keeping all sixteen subkeys in parallel registers.

A load pulse captures the key and the direction. The 56 non-parity key bits are kept as two 28-bit halves. Each accepted step rotates both halves by the amount the round schedule gives, to the left for encryption and to the right for decryption. An output register holds the compressed 48-bit key of the halves. A valid flag marks when that register matches the reported round position. The round position counts 1 to 16 in delivery order. In decryption order, position 1 carries the subkey of round 16.

Top module: `des_round_key_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `round_idx` = 0, `key_valid` = 0 and `round_key` = 0.
- R2: A `load` sampled at an edge sets `round_idx` to 1 and `key_valid` to 0 after that edge. After the following edge `key_valid` is 1 and `round_key` holds the first key of the sequence.
- R3: With `decrypt` low at load, position p (1..16) delivers round key p. Both halves are rotated left cumulatively, by one bit in rounds 1, 2, 9 and 16 and by two bits in every other round. Key bit 1 is `key_in[63]` and round key bit 1 is `round_key[47]`.
- R4: The eight parity bits `key_in[0]`, `key_in[8]`, ..., `key_in[56]` have no effect on any delivered key.
- R5: With `decrypt` high at load, position p delivers round key 17-p. The first key comes from the unrotated halves, and each later key comes from a right rotation by the schedule amount of the round just delivered.
- R6: A step is accepted only while `key_valid` is 1. An accepted step raises `round_idx` by one, clears `key_valid` for one cycle, and then shows the next key. A step seen while `key_valid` is 0 is ignored.
- R7: A step at position 16 is ignored: `round_idx` stays 16, `key_valid` stays 1 and `round_key` is unchanged.
- R8: A load in the middle of a sequence restarts at position 1 with the new key and direction, and it takes priority over a step in the same cycle.
- R9: `decrypt` is sampled only at load; changing it mid-sequence has no effect.
- R10: `key_in` is sampled only at load; changing it mid-sequence has no effect.
- R11: While neither load nor step occurs and `key_valid` is 1, `round_key`, `round_idx` and `key_valid` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | 64 | Cipher key, DES bit 1 at bit 63 |
| load | input | 1 | Capture key and direction, restart at position 1 |
| step | input | 1 | Advance to the next round key |
| decrypt | input | 1 | Direction sampled at load: 1 selects reverse key order |
| round_key | output | 48 | Current round subkey |
| round_idx | output | 5 | Delivery position 1..16, 0 after reset |
| key_valid | output | 1 | round_key matches round_idx |

## Verification
The assertions check the sequencing rules on every cycle. These are the restart on load, the one-cycle valid gap after each accepted step, the hold while idle, the upper bound on the position and the refusal of steps at position 16. Whether each delivered key has the correct bit value cannot be shown by the assertions. Only the bench scenarios show it, by comparing every key of full encryption and decryption sequences against a reference schedule. These scenarios include random keys, a known key, flipped parity bits, restarts mid-sequence and inputs that change while they are not being sampled.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;

    localparam int KEY_W  = 64;
    localparam int CD_W   = 56;
    localparam int HALF_W = CD_W / 2;
    localparam int RK_W   = 48;
    localparam int ROUNDS = 16;
    localparam int IDX_W  = $clog2(ROUNDS + 1);

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [RK_W-1:0]   rkey_t;

    typedef struct packed {
        half_t c;   // DES bits 1..28 of the reduced key
        half_t d;   // DES bits 29..56
    } halves_t;

    // Selection lists, DES numbering (bit 1 is the MSB)
    localparam int unsigned PC1_SEL [CD_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };

    localparam int unsigned PC2_SEL [RK_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    // Rotation amount of a given round (1..16)
    function automatic logic [1:0] shift_of(input idx_t rnd);
        if (rnd == idx_t'(1) || rnd == idx_t'(2) ||
            rnd == idx_t'(9) || rnd == idx_t'(ROUNDS))
            return 2'd1;
        return 2'd2;
    endfunction

    function automatic halves_t reduce_key(input logic [KEY_W-1:0] k);
        logic [CD_W-1:0] v;
        for (int i = 0; i < CD_W; i++)
            v[CD_W-1-i] = k[KEY_W - int'(PC1_SEL[i])];
        return halves_t'(v);
    endfunction

    function automatic rkey_t compress(input halves_t h);
        logic [CD_W-1:0] v;
        rkey_t r;
        v = h;
        for (int i = 0; i < RK_W; i++)
            r[RK_W-1-i] = v[CD_W - int'(PC2_SEL[i])];
        return r;
    endfunction

    function automatic half_t rot_left(input half_t x, input logic [1:0] n);
        case (n)
            2'd1:    return {x[HALF_W-2:0], x[HALF_W-1]};
            2'd2:    return {x[HALF_W-3:0], x[HALF_W-1:HALF_W-2]};
            default: return x;
        endcase
    endfunction

    function automatic half_t rot_right(input half_t x, input logic [1:0] n);
        case (n)
            2'd1:    return {x[0], x[HALF_W-1:1]};
            2'd2:    return {x[1:0], x[HALF_W-1:2]};
            default: return x;
        endcase
    endfunction

endpackage

// File: rtl/des_ks_ctrl.sv
module des_ks_ctrl
    import des_ks_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    input  logic decrypt,
    output idx_t idx,
    output logic valid,
    output logic dir_dec,
    output logic adv
);
    logic pend;

    assign adv = !load && step && valid && (idx < idx_t'(ROUNDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            valid   <= 1'b0;
            pend    <= 1'b0;
            dir_dec <= 1'b0;
        end else if (load) begin
            idx     <= idx_t'(1);
            valid   <= 1'b0;
            pend    <= 1'b1;
            dir_dec <= decrypt;
        end else if (adv) begin
            idx     <= idx + idx_t'(1);
            valid   <= 1'b0;
            pend    <= 1'b1;
        end else if (pend) begin
            valid   <= 1'b1;
            pend    <= 1'b0;
        end
    end
endmodule

// File: rtl/des_ks_halves.sv
module des_ks_halves
    import des_ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             load_dec,
    input  logic [KEY_W-1:0] key_in,
    input  logic             adv,
    input  logic             dir_dec,
    input  idx_t             idx,
    output halves_t          halves
);
    halves_t    reduced;
    halves_t    first_h;
    halves_t    next_h;
    logic [1:0] amt;

    assign reduced = reduce_key(key_in);

    always_comb begin
        // Encryption starts on round 1, decryption on the unrotated round 16
        first_h = reduced;
        if (!load_dec) begin
            first_h.c = rot_left(reduced.c, shift_of(idx_t'(1)));
            first_h.d = rot_left(reduced.d, shift_of(idx_t'(1)));
        end
    end

    always_comb begin
        next_h = halves;
        if (dir_dec) begin
            amt      = shift_of(idx_t'(ROUNDS + 1) - idx);
            next_h.c = rot_right(halves.c, amt);
            next_h.d = rot_right(halves.d, amt);
        end else begin
            amt      = shift_of(idx + idx_t'(1));
            next_h.c = rot_left(halves.c, amt);
            next_h.d = rot_left(halves.d, amt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            halves <= '0;
        else if (load)
            halves <= first_h;
        else if (adv)
            halves <= next_h;
    end
endmodule

// File: rtl/des_ks_out.sv
module des_ks_out
    import des_ks_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  halves_t halves,
    output rkey_t   round_key
);
    always_ff @(posedge clk) begin
        if (rst)
            round_key <= '0;
        else
            round_key <= compress(halves);
    end
endmodule

// File: rtl/des_round_key_seq.sv
module des_round_key_seq
    import des_ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              load,
    input  logic              step,
    input  logic              decrypt,
    output logic [RK_W-1:0]   round_key,
    output logic [IDX_W-1:0]  round_idx,
    output logic              key_valid
);
    idx_t    idx;
    logic    dir_dec;
    logic    adv;
    halves_t halves;

    des_ks_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step    (step),
        .decrypt (decrypt),
        .idx     (idx),
        .valid   (key_valid),
        .dir_dec (dir_dec),
        .adv     (adv)
    );

    des_ks_halves u_halves (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_dec (decrypt),
        .key_in   (key_in),
        .adv      (adv),
        .dir_dec  (dir_dec),
        .idx      (idx),
        .halves   (halves)
    );

    des_ks_out u_out (
        .clk       (clk),
        .rst       (rst),
        .halves    (halves),
        .round_key (round_key)
    );

    assign round_idx = idx;
endmodule

// File: rtl/des_round_key_seq_chk.sv
module des_round_key_seq_chk
    import des_ks_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic             step,
    input logic [RK_W-1:0]  round_key,
    input logic [IDX_W-1:0] round_idx,
    input logic             key_valid
);
    a_r2_load_restarts: assert property (@(posedge clk) disable iff (rst)
        load |=> (round_idx == IDX_W'(1) && !key_valid));

    a_r6_gap_completes: assert property (@(posedge clk) disable iff (rst)
        (!key_valid && round_idx != '0 && !load) |=> key_valid);

    a_r6_step_accepted: assert property (@(posedge clk) disable iff (rst)
        (step && key_valid && !load && round_idx < IDX_W'(ROUNDS))
        |=> (round_idx == $past(round_idx) + IDX_W'(1) && !key_valid));

    a_r7_end_holds: assert property (@(posedge clk) disable iff (rst)
        (step && key_valid && !load && round_idx == IDX_W'(ROUNDS))
        |=> (round_idx == IDX_W'(ROUNDS) && key_valid && $stable(round_key)));

    a_r7_idx_bound: assert property (@(posedge clk) disable iff (rst)
        round_idx <= IDX_W'(ROUNDS));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (key_valid && !step && !load)
        |=> (key_valid && $stable(round_key) && $stable(round_idx)));
endmodule

bind des_round_key_seq des_round_key_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .round_key (round_key),
    .round_idx (round_idx),
    .key_valid (key_valid)
);

// File: tb/des_round_key_seq_tb.sv
module des_round_key_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] key_in = '0;
    logic        load = 1'b0;
    logic        step = 1'b0;
    logic        decrypt = 1'b0;
    logic [47:0] round_key;
    logic [4:0]  round_idx;
    logic        key_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    des_round_key_seq u_dut (
        .clk(clk), .rst(rst), .key_in(key_in), .load(load), .step(step),
        .decrypt(decrypt), .round_key(round_key), .round_idx(round_idx),
        .key_valid(key_valid)
    );

    // Reference schedule, written from the requirements
    localparam int T1 [56] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};
    localparam int T2 [48] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

    function automatic logic [47:0] ref_key(input logic [63:0] k, input int n);
        logic [55:0] cd;
        logic [27:0] c, d;
        logic [47:0] r;
        int tot = 0;
        for (int i = 0; i < 56; i++) cd[55-i] = k[64-T1[i]];
        c = cd[55:28];
        d = cd[27:0];
        for (int j = 1; j <= n; j++)
            tot += (j == 1 || j == 2 || j == 9 || j == 16) ? 1 : 2;
        for (int s = 0; s < tot; s++) begin
            c = {c[26:0], c[27]};
            d = {d[26:0], d[27]};
        end
        cd = {c, d};
        for (int i = 0; i < 48; i++) r[47-i] = cd[56-T2[i]];
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Full sequence with noise on key_in and decrypt after load (R9, R10)
    task automatic run_seq(input logic [63:0] k, input logic dec, input logic [63:0] kexp);
        logic [47:0] last;
        string tag;
        tag = dec ? "R5" : "R3";
        key_in = k; decrypt = dec; load = 1'b1;
        tick();
        load = 1'b0; key_in = {$urandom, $urandom}; decrypt = ~dec;
        check("R2 idx after load", 64'(round_idx), 64'd1);
        check("R2 valid low after load", 64'(key_valid), 64'd0);
        tick();
        check("R2 valid", 64'(key_valid), 64'd1);
        check({tag, " first key"}, 64'(round_key), 64'(ref_key(kexp, dec ? 16 : 1)));
        for (int p = 2; p <= 16; p++) begin
            step = 1'b1;
            tick();
            step = 1'b0;
            check("R6 idx advance", 64'(round_idx), 64'(p));
            check("R6 valid gap", 64'(key_valid), 64'd0);
            tick();
            check({tag, " R9 R10 key"}, 64'(round_key), 64'(ref_key(kexp, dec ? 17 - p : p)));
        end
        last = round_key;
        step = 1'b1;
        tick();
        step = 1'b0;
        check("R7 idx stays", 64'(round_idx), 64'd16);
        check("R7 valid stays", 64'(key_valid), 64'd1);
        check("R7 key stays", 64'(round_key), 64'(last));
        tick();
        check("R11 hold", 64'(round_key), 64'(last));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] k;
        void'($urandom(32'd20240611));
        tick(); tick(); tick();
        check("R1 idx", 64'(round_idx), 64'd0);
        check("R1 valid", 64'(key_valid), 64'd0);
        check("R1 key", 64'(round_key), 64'd0);
        rst = 1'b0;
        tick();

        // Known key anchor values for round 1 and round 16 (R3, R5)
        key_in = 64'h133457799BBCDFF1; decrypt = 1'b0; load = 1'b1;
        tick(); load = 1'b0; tick();
        check("R3 known round 1", 64'(round_key), 64'h1B02EFFC7072);
        key_in = 64'h133457799BBCDFF1; decrypt = 1'b1; load = 1'b1;
        tick(); load = 1'b0; tick();
        check("R5 known round 16", 64'(round_key), 64'hCB3D8B0E17F5);

        run_seq(64'h133457799BBCDFF1, 1'b0, 64'h133457799BBCDFF1);
        run_seq(64'h133457799BBCDFF1, 1'b1, 64'h133457799BBCDFF1);
        run_seq(64'h0, 1'b0, 64'h0);
        run_seq(64'hFFFFFFFFFFFFFFFF, 1'b1, 64'hFFFFFFFFFFFFFFFF);

        // R4: parity bits flipped, expected keys from the unflipped key
        k = 64'h0E329232EA6D0D73;
        run_seq(k ^ 64'h0101010101010101, 1'b0, k);
        run_seq(k ^ 64'h0101010101010101, 1'b1, k);
        check("R4 marker", 64'(round_key), 64'(ref_key(k, 1)));

        // R6: step held high, only every second cycle is accepted
        k = {$urandom, $urandom};
        key_in = k; decrypt = 1'b0; load = 1'b1;
        tick(); load = 1'b0; tick();
        step = 1'b1;
        for (int p = 2; p <= 16; p++) begin
            tick(); tick();
            check("R6 held step idx", 64'(round_idx), 64'(p));
            check("R6 held step key", 64'(round_key), 64'(ref_key(k, p)));
        end
        tick(); tick();
        check("R7 held step end", 64'(round_idx), 64'd16);
        step = 1'b0;

        // R8: reload mid-sequence, load wins over step, direction resampled
        k = {$urandom, $urandom};
        key_in = k; decrypt = 1'b0; load = 1'b1;
        tick(); load = 1'b0; tick();
        for (int p = 2; p <= 5; p++) begin
            step = 1'b1; tick(); step = 1'b0; tick();
        end
        check("R8 mid idx", 64'(round_idx), 64'd5);
        k = {$urandom, $urandom};
        key_in = k; decrypt = 1'b1; load = 1'b1; step = 1'b1;
        tick();
        load = 1'b0; step = 1'b0;
        check("R8 restart idx", 64'(round_idx), 64'd1);
        tick();
        check("R8 restart key", 64'(round_key), 64'(ref_key(k, 16)));
        step = 1'b1; tick(); step = 1'b0; tick();
        check("R8 reverse second", 64'(round_key), 64'(ref_key(k, 15)));

        // Random keys and directions
        for (int n = 0; n < 24; n++) begin
            k = {$urandom, $urandom};
            run_seq(k, 1'($urandom), k);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule